// File: doc/BRIEF.md
# Bus Release Arbiter with DMA Lock

This block decides when the chip's local bus may be handed to an external master. The external master raises a request, and the block samples it only when no local-bus access is in flight. When it grants, the block first stops driving the bus controls. One cycle later it raises acknowledge. When the request drops, acknowledge falls first and the bus controls are driven again one cycle after that. While the bus is away, any CPU or DMA access to the local window is held off with a per-requester wait line.

DMA transfers can restrain a release. When the lock is in effect (lock-disable input low), the block reacts to where each side of the transfer sits:
- If the DMA reads from the local window, no release happens between the read and the write.
- If that read is also followed by a write outside the window, the release stays held after the write. It is freed only once a CPU access to the local window completes.
- A transfer that only writes into the window may release in the gap between read and write.

With the lock disabled, only the ordinary access-boundary rule applies.

Top module: `bus_release_arb`

## Requirements
- R1: While reset is active and until the internal synchronised reset releases, `ext_ack` is 0, `bus_drive` is 1 and every `loc_wait` bit is 0.
- R2: With `bus_drive`=1, `acc_busy`=0 and no DMA restraint, a high `ext_req` at a clock edge makes `bus_drive` 0 after that edge (acknowledge still 0), and `ext_ack` 1 after the following edge.
- R3: `ext_req` is not acted on while `acc_busy`=1; the bus stays driven, and the grant sequence of R2 starts at the first edge with `acc_busy`=0.
- R4: With `ext_ack`=1 and `ext_req` low at an edge, `ext_ack` becomes 0 after that edge and `bus_drive` returns to 1 after the next one; a request withdrawn while the bus is floating but not yet acknowledged also returns the bus that way.
- R5: `loc_wait[i]` equals `loc_req[i]` whenever `bus_drive` is 0 and is 0 whenever `bus_drive` is 1; bit 0 is the CPU, bit 1 the DMA engine.
- R6: With `dma_nolock`=0 and `dma_src_in`=1, after a `dma_rd_done` pulse no grant starts until the edge after the `dma_wr_done` pulse.
- R7: With `dma_nolock`=0, `dma_src_in`=1 and `dma_dst_in`=0, a grant stays withheld after `dma_wr_done` for as long as no `cpu_done` pulse arrives.
- R8: In the held case of R7, a `cpu_done` pulse frees the bus: `bus_drive` falls one edge later, so two edges after the pulse, and `ext_ack` rises the edge after that.
- R9: With `dma_nolock`=0, `dma_src_in`=0 and `dma_dst_in`=1, a request is granted between `dma_rd_done` and `dma_wr_done`.
- R10: With `dma_nolock`=1, the DMA pulses impose no restraint; after a read inside and a write outside the window a request is granted by R2 timing without any CPU access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchroniser |
| ext_req | input | 1 | Bus request from the external master |
| ext_ack | output | 1 | Bus acknowledge to the external master |
| bus_drive | output | 1 | 1 while the chip drives the local bus controls, 0 while they float |
| acc_busy | input | 1 | A local-window access is in progress |
| loc_req | input | N_MST | Local-window access requests (bit 0 CPU, bit 1 DMA) |
| loc_wait | output | N_MST | Wait for each requester while the bus is released |
| cpu_done | input | 1 | Pulse: a CPU access to the local window completes |
| dma_rd_done | input | 1 | Pulse: the DMA read phase of a transfer ends |
| dma_wr_done | input | 1 | Pulse: the DMA write phase of a transfer ends |
| dma_src_in | input | 1 | DMA source lies in the local window |
| dma_dst_in | input | 1 | DMA destination lies in the local window |
| dma_nolock | input | 1 | 1 = lock not in effect for the active DMA channel |

## Verification
The float step is due one edge after the request is sampled and acknowledge one edge later still. The return of the drive follows the fall of acknowledge by one edge. Releasing a held lock costs one more edge: the flag clears first, and the grant starts at the next edge. The bench applies inputs just after a falling edge and reads outputs at the next falling edge. Each check is therefore placed a counted number of rising edges after its stimulus, and in-between checks confirm that nothing moves early.

// File: rtl/brarb_pkg.sv
package brarb_pkg;
  typedef enum logic [1:0] {
    HS_OWN    = 2'd0,
    HS_FLOAT  = 2'd1,
    HS_GRANT  = 2'd2,
    HS_RETURN = 2'd3
  } hs_state_e;
endpackage

// File: rtl/brarb_rst_sync.sv
module brarb_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_s
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_s = sync_q[STAGES-1];
endmodule

// File: rtl/brarb_lock_track.sv
module brarb_lock_track (
  input  logic clk,
  input  logic rst_n,
  input  logic rd_done,
  input  logic wr_done,
  input  logic cpu_done,
  input  logic src_in,
  input  logic dst_in,
  input  logic nolock,
  output logic pair_hold,
  output logic held_lock
);
  logic pair_q, pair_d, pair_en;
  logic held_q, held_d, held_en;
  logic locked;

  assign locked = !nolock;

  always_comb begin
    pair_en = 1'b0;
    pair_d  = pair_q;
    if (rd_done && locked && src_in) begin
      pair_en = 1'b1;
      pair_d  = 1'b1;
    end else if (wr_done) begin
      pair_en = 1'b1;
      pair_d  = 1'b0;
    end
  end

  always_comb begin
    held_en = 1'b0;
    held_d  = held_q;
    if (wr_done && locked && src_in && !dst_in) begin
      held_en = 1'b1;
      held_d  = 1'b1;
    end else if (cpu_done) begin
      held_en = 1'b1;
      held_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       pair_q <= 1'b0;
    else if (pair_en) pair_q <= pair_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       held_q <= 1'b0;
    else if (held_en) held_q <= held_d;
  end

  assign pair_hold = pair_q;
  assign held_lock = held_q;

  // R6
  pair_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pair_q && !wr_done) |=> pair_q);

  // R7
  held_persist_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (held_q && !cpu_done) |=> held_q);
endmodule

// File: rtl/brarb_handover.sv
module brarb_handover
  import brarb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic grant_ok,
  input  logic ext_req,
  output logic bus_drive,
  output logic ext_ack
);
  hs_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      HS_OWN:    if (grant_ok) state_d = HS_FLOAT;
      HS_FLOAT:  state_d = ext_req ? HS_GRANT : HS_RETURN;
      HS_GRANT:  if (!ext_req) state_d = HS_RETURN;
      HS_RETURN: state_d = HS_OWN;
      default:   state_d = HS_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= HS_OWN;
    else        state_q <= state_d;
  end

  assign bus_drive = (state_q == HS_OWN);
  assign ext_ack   = (state_q == HS_GRANT);

  // R2
  float_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ext_ack) |-> !$past(bus_drive));

  // R4
  drop_floating_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ack) |-> !bus_drive);

  // R4
  redrive_next_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ext_ack) |=> bus_drive);
endmodule

// File: rtl/bus_release_arb.sv
module bus_release_arb #(
  parameter int N_MST       = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ext_req,
  output logic             ext_ack,
  output logic             bus_drive,
  input  logic             acc_busy,
  input  logic [N_MST-1:0] loc_req,
  output logic [N_MST-1:0] loc_wait,
  input  logic             cpu_done,
  input  logic             dma_rd_done,
  input  logic             dma_wr_done,
  input  logic             dma_src_in,
  input  logic             dma_dst_in,
  input  logic             dma_nolock
);
  logic rst_n_s;
  logic pair_hold, held_lock;
  logic grant_ok;

  brarb_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .rst_n   (rst_n),
    .rst_n_s (rst_n_s)
  );

  brarb_lock_track u_lock (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .rd_done   (dma_rd_done),
    .wr_done   (dma_wr_done),
    .cpu_done  (cpu_done),
    .src_in    (dma_src_in),
    .dst_in    (dma_dst_in),
    .nolock    (dma_nolock),
    .pair_hold (pair_hold),
    .held_lock (held_lock)
  );

  assign grant_ok = ext_req && !acc_busy && !pair_hold && !held_lock;

  brarb_handover u_hs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .grant_ok  (grant_ok),
    .ext_req   (ext_req),
    .bus_drive (bus_drive),
    .ext_ack   (ext_ack)
  );

  for (genvar i = 0; i < N_MST; i++) begin : g_stall
    assign loc_wait[i] = loc_req[i] && !bus_drive;
  end

  // R3
  restrain_keeps_bus_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (bus_drive && (acc_busy || pair_hold || held_lock)) |=> bus_drive);
endmodule

// File: tb/sim_bus_release_arb.sv
`timescale 1ns/100ps
module sim_bus_release_arb;
  localparam int N_MST = 2;

  logic clk = 1'b0;
  logic rst_n;
  logic ext_req, acc_busy, cpu_done, dma_rd_done, dma_wr_done;
  logic dma_src_in, dma_dst_in, dma_nolock;
  logic [N_MST-1:0] loc_req;
  logic ext_ack, bus_drive;
  logic [N_MST-1:0] loc_wait;

  int checks = 0;
  int fails  = 0;

  always #2.5 clk = ~clk;

  bus_release_arb #(.N_MST(N_MST)) u0 (
    .clk(clk), .rst_n(rst_n), .ext_req(ext_req), .ext_ack(ext_ack),
    .bus_drive(bus_drive), .acc_busy(acc_busy), .loc_req(loc_req),
    .loc_wait(loc_wait), .cpu_done(cpu_done), .dma_rd_done(dma_rd_done),
    .dma_wr_done(dma_wr_done), .dma_src_in(dma_src_in),
    .dma_dst_in(dma_dst_in), .dma_nolock(dma_nolock)
  );

  // entry: [11:8] requirement number, [7:4] {ext_req,acc_busy,loc_req},
  // [3:0] expected {ext_ack,bus_drive,loc_wait}
  // R2 grant steps, R3 busy hold-off, R4 return steps, R5 waits
  localparam int NV = 11;
  localparam logic [11:0] VEC [NV] = '{
    12'h504, 12'h3D4, 12'h3C4, 12'h280, 12'h2BB, 12'h5AA,
    12'h411, 12'h414, 12'h280, 12'h400, 12'h404
  };

  task automatic chk(input string tag, input logic [3:0] act, input logic [3:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual={ack,drv,wait}=%b expected=%b", tag, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {ext_ack, bus_drive, loc_wait};
  endfunction

  task automatic step();
    @(negedge clk);
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog expired");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 1'b0; ext_req = 0; acc_busy = 0; cpu_done = 0;
    dma_rd_done = 0; dma_wr_done = 0; dma_src_in = 0; dma_dst_in = 0;
    dma_nolock = 0; loc_req = 2'b11;
    repeat (3) step();
    chk("R1 in reset", outs(), 4'b0100);
    ext_req = 1'b1;
    rst_n = 1'b1;
    step();
    chk("R1 during sync release", outs(), 4'b0100);
    ext_req = 1'b0; loc_req = 2'b00;
    repeat (3) step();
    chk("R1 after release", outs(), 4'b0100);

    for (int k = 0; k < NV; k++) begin
      {ext_req, acc_busy, loc_req} = VEC[k][7:4];
      step();
      chk($sformatf("R%0d vector %0d", VEC[k][11:8], k), outs(), VEC[k][3:0]);
    end

    // R6: locked, both sides in window
    dma_nolock = 0; dma_src_in = 1; dma_dst_in = 1;
    dma_rd_done = 1; step(); dma_rd_done = 0;
    ext_req = 1; repeat (4) step();
    chk("R6 no release between read and write", outs(), 4'b0100);
    dma_wr_done = 1; step(); dma_wr_done = 0;
    step(); step();
    chk("R6 granted after write", outs(), 4'b1000);
    ext_req = 0; step(); step();
    chk("R6 bus returned", outs(), 4'b0100);

    // R7/R8: locked, read inside, write outside
    dma_src_in = 1; dma_dst_in = 0;
    dma_rd_done = 1; step(); dma_rd_done = 0;
    dma_wr_done = 1; step(); dma_wr_done = 0;
    ext_req = 1; loc_req = 2'b01; repeat (5) step();
    chk("R7 held after outside write", outs(), 4'b0100);
    loc_req = 2'b00;
    cpu_done = 1; step(); cpu_done = 0;
    chk("R8 one edge after cpu done", outs(), 4'b0100);
    step();
    chk("R8 floats after cpu done", outs(), 4'b0000);
    step();
    chk("R8 ack after cpu done", outs(), 4'b1000);
    ext_req = 0; step(); step();

    // R9: locked, read outside, write inside
    dma_src_in = 0; dma_dst_in = 1;
    dma_rd_done = 1; ext_req = 1; step(); dma_rd_done = 0;
    step();
    chk("R9 granted between read and write", outs(), 4'b1000);
    ext_req = 0; step(); step();
    dma_wr_done = 1; step(); dma_wr_done = 0;

    // R10: lock not in effect, read inside, write outside
    dma_nolock = 1; dma_src_in = 1; dma_dst_in = 0;
    dma_rd_done = 1; step(); dma_rd_done = 0;
    dma_wr_done = 1; step(); dma_wr_done = 0;
    ext_req = 1; step();
    chk("R10 floats without cpu access", outs(), 4'b0000);
    step();
    chk("R10 ack without cpu access", outs(), 4'b1000);
    ext_req = 0; step(); step();
    chk("R10 bus returned", outs(), 4'b0100);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule